// File: doc/BRIEF.md
# Serial Port FIFO and Status Front End

This block sits between a simple register bus and the bit shifter of a synchronous serial port. Software writes outgoing words through a 16-bit data register, and the block queues them in an 8-entry transmit FIFO. Received words come back through the same register in arrival order from an 8-entry receive FIFO. A status register gives the fill state of both queues and a busy indication. A prescale register sets an even divisor for the peripheral clock.

The shifter works through a frame handshake. It sees `tx_valid` and `tx_word`, pulses `tx_pop` to take a word, pulses `rx_push` with `rx_word` to hand in a received frame, and drives `eng_busy` while it shifts. The frame length, from 4 to 16 bits, is a configuration input. Transmit words are cut down to their low-order bits. Received words are stored right-justified with the upper bits cleared. The prescaler sends a one-cycle bit-rate enable to the shifter.

Top module: `ssp_front`

## Requirements
- R1: After reset the status register reads 0x03, the prescale register reads 0, and a data read returns 0.
- R2: A bus write to the data register (addr 0) pushes into the transmit FIFO. When 8 words are queued, the not-full flag is 0 and further writes are dropped.
- R3: `tx_valid` is 1 in the cycle after a write into an empty transmit FIFO. `tx_word` shows the queued words in write order, and each `tx_pop` advances it.
- R4: `tx_word` carries only the low `frame_bits` bits of the head word. All higher bits are 0. Values of `frame_bits` outside 4..16 are clamped to that range.
- R5: A read of the data register returns the oldest received frame, right-justified and with the bits above `frame_bits` cleared. The read pops that frame.
- R6: A data read while the receive FIFO is empty returns 0 and leaves both FIFOs unchanged.
- R7: The status register (addr 1) has this layout: bit 0 is transmit empty, bit 1 is transmit not full, bit 2 is receive not empty, bit 3 is receive full, bit 4 is busy. Bits 15:5 read as 0.
- R8: Busy is 1 when `eng_busy` is 1 or the transmit FIFO holds any word. Otherwise it is 0.
- R9: An `rx_push` while the receive FIFO is full is discarded and sets the sticky `overrun` output. Only reset clears `overrun`.
- R10: A write to the prescale register (addr 2) stores the value with bit 0 forced to 0. The register reads back as stored.
- R11: With a divisor D other than 0, `sck_en` is a one-cycle pulse every D clock cycles. With a divisor of 0, `sck_en` stays 0.
- R12: Writes to the status register and to addr 3 have no effect on any register or FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 prescale |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive data when addr is 0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| frame_bits | input | 5 | Frame length in bits, 4 to 16 |
| tx_valid | output | 1 | Transmit FIFO holds a word |
| tx_word | output | 16 | Head transmit word, masked to the frame length |
| tx_pop | input | 1 | Shifter takes the head transmit word |
| rx_push | input | 1 | Shifter delivers a received frame |
| rx_word | input | 16 | Received frame data |
| eng_busy | input | 1 | Shifter is moving a frame |
| sck_en | output | 1 | Bit-rate enable pulse from the prescaler |
| overrun | output | 1 | Sticky flag: a received frame was lost |

## Verification
A wrong FIFO pointer or count shows up on the status register, `tx_valid` or `tx_word` in the cycle after the faulty push or pop. From then on, every later pop returns a word out of order or a stale word. A fault in the masking or clamping logic changes the upper bits of `tx_word` or of the data read value at once. A fault in the prescaler counter changes the spacing of `sck_en` pulses on the first interval after a divisor is written. The bench measures that spacing for small, mid and maximum divisors.

// File: rtl/ssp_front_pkg.sv
package ssp_front_pkg;
  localparam int SSP_DW = 16;

  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_STATUS = 2'd1,
    REG_PRESC  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // Mask that keeps the low n bits, with n clamped to 4..16.
  function automatic logic [SSP_DW-1:0] frame_mask(input logic [4:0] n);
    logic [4:0] k;
    k = n;
    if (k < 5'd4) k = 5'd4;
    if (k > 5'd16) k = 5'd16;
    return {SSP_DW{1'b1}} >> (5'd16 - k);
  endfunction

  // Even divisor: clear bit 0.
  function automatic logic [7:0] even_div(input logic [7:0] v);
    return {v[7:1], 1'b0};
  endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         push_ok,
  output logic         pop_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ssp_prescaler.sv
module ssp_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else if (div_wr) begin
      div_q <= {div_in[DIV_W-1:1], 1'b0};
      cnt   <= '0;
      tick  <= 1'b0;
    end else if (div_q == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div_q - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_front.sv
module ssp_front
  import ssp_front_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [4:0]  frame_bits,
  output logic        tx_valid,
  output logic [15:0] tx_word,
  input  logic        tx_pop,
  input  logic        rx_push,
  input  logic [15:0] rx_word,
  input  logic        eng_busy,
  output logic        sck_en,
  output logic        overrun
);
  logic [SSP_DW-1:0] mask;
  logic              wr_data, rd_data, wr_presc;
  logic [SSP_DW-1:0] tx_head, rx_head;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic [7:0]        div_q;
  logic [7:0]        status;
  logic              busy;

  assign mask     = frame_mask(frame_bits);
  assign wr_data  = bus_wr && (bus_addr == REG_DATA);
  assign rd_data  = bus_rd && (bus_addr == REG_DATA);
  assign wr_presc = bus_wr && (bus_addr == REG_PRESC);

  ssp_fifo #(.W(SSP_DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_data), .pop(tx_pop),
    .din(bus_wdata), .dout(tx_head), .empty(tx_empty), .full(tx_full),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  ssp_fifo #(.W(SSP_DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rd_data),
    .din(rx_word & mask), .dout(rx_head), .empty(rx_empty), .full(rx_full),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  ssp_prescaler #(.DIV_W(8)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_wr(wr_presc), .div_in(bus_wdata[7:0]),
    .div_q(div_q), .tick(sck_en)
  );

  assign tx_valid = !tx_empty;
  assign tx_word  = tx_head & mask;
  assign busy     = eng_busy || !tx_empty;
  assign status   = {3'b000, busy, rx_full, !rx_empty, !tx_full, tx_empty};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                overrun <= 1'b0;
    else if (rx_push && rx_full) overrun <= 1'b1;
  end

  always_comb begin
    case (bus_addr)
      REG_DATA:   bus_rdata = rx_empty ? '0 : rx_head;
      REG_STATUS: bus_rdata = {8'h00, status};
      REG_PRESC:  bus_rdata = {8'h00, div_q};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ssp_front_chk.sv
module ssp_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        wr_data,
  input logic        tx_full,
  input logic        tx_empty,
  input logic        tx_pop,
  input logic        tx_valid,
  input logic        rx_push,
  input logic        rx_full,
  input logic        rx_empty,
  input logic [15:0] bus_rdata,
  input logic [7:0]  div_q,
  input logic        sck_en,
  input logic        overrun
);
  assert_tx_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full && !tx_pop) |=> tx_full);

  assert_tx_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_empty) |=> tx_valid);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0 && rx_empty) |-> (bus_rdata == 16'h0000));

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> overrun);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_div_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !div_q[0]);

  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sck_en |=> !sck_en);

  assert_tick_zero_div_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == 8'd0) |-> !sck_en);
endmodule

bind ssp_front ssp_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_data(wr_data),
  .tx_full(tx_full), .tx_empty(tx_empty), .tx_pop(tx_pop), .tx_valid(tx_valid),
  .rx_push(rx_push), .rx_full(rx_full), .rx_empty(rx_empty),
  .bus_rdata(bus_rdata), .div_q(div_q), .sck_en(sck_en), .overrun(overrun)
);

// File: tb/ssp_front_tb.sv
module ssp_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  frame_bits = 5'd16;
  logic        tx_valid, tx_pop = 1'b0;
  logic [15:0] tx_word;
  logic        rx_push = 1'b0;
  logic [15:0] rx_word = '0;
  logic        eng_busy = 1'b0;
  logic        sck_en, overrun;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ssp_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_bits(frame_bits), .tx_valid(tx_valid), .tx_word(tx_word),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .eng_busy(eng_busy), .sck_en(sck_en), .overrun(overrun)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = (a == 2'd0);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pop_tx(input string req, input logic [15:0] exp);
    @(negedge clk);
    check(req, {15'd0, tx_valid}, 16'd1);
    check(req, tx_word, exp);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [15:0] d);
    @(negedge clk);
    rx_word = d; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  function automatic logic [15:0] mask_of(input int n);
    int k = (n < 4) ? 4 : (n > 16 ? 16 : n);
    return 16'((32'h1 << k) - 1);
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    peek(2'd1, d); check("R1 status", d, 16'h0003);
    peek(2'd2, d); check("R1 prescale", d, 16'h0000);
    peek(2'd0, d); check("R1 data", d, 16'h0000);
  endtask

  task automatic t_tx_fill();
    logic [15:0] d;
    frame_bits = 5'd16;
    bus_write(2'd0, 16'h1000);
    check("R3 tx_valid after write", {15'd0, tx_valid}, 16'd1);
    peek(2'd1, d); check("R7 status one word", d, 16'h0012);
    for (int i = 1; i < 8; i++) bus_write(2'd0, 16'h1000 + 16'(i));
    peek(2'd1, d); check("R2 status full", d, 16'h0010);
    bus_write(2'd0, 16'hDEAD);
    for (int i = 0; i < 8; i++) pop_tx("R3 order", 16'h1000 + 16'(i));
    @(negedge clk);
    check("R2 dropped word absent", {15'd0, tx_valid}, 16'd0);
    peek(2'd1, d); check("R8 idle status", d, 16'h0003);
  endtask

  task automatic t_mask();
    frame_bits = 5'd8;
    bus_write(2'd0, 16'hABCD);
    @(negedge clk); check("R4 8-bit mask", tx_word, 16'h00CD);
    frame_bits = 5'd2;
    @(negedge clk); check("R4 clamp low", tx_word, 16'h000D);
    frame_bits = 5'd20;
    @(negedge clk); check("R4 clamp high", tx_word, 16'hABCD);
    frame_bits = 5'd16;
    pop_tx("R4 pop", 16'hABCD);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    eng_busy = 1'b1;
    peek(2'd1, d); check("R8 busy from engine", d, 16'h0013);
    eng_busy = 1'b0;
    peek(2'd1, d); check("R8 not busy", d, 16'h0003);
  endtask

  task automatic t_rx();
    logic [15:0] d;
    frame_bits = 5'd12;
    push_rx(16'hF123);
    peek(2'd1, d); check("R7 rne", d, 16'h0007);
    push_rx(16'hFFFF);
    push_rx(16'h0ABC);
    bus_read(2'd0, d); check("R5 first", d, 16'h0123 & mask_of(12));
    bus_read(2'd0, d); check("R5 second", d, 16'h0FFF);
    bus_read(2'd0, d); check("R5 third", d, 16'h0ABC);
    bus_read(2'd0, d); check("R6 empty read", d, 16'h0000);
    peek(2'd1, d); check("R6 status unchanged", d, 16'h0003);
    frame_bits = 5'd16;
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    for (int i = 0; i < 8; i++) push_rx(16'h5500 + 16'(i));
    peek(2'd1, d); check("R7 rx full", d, 16'h000F);
    check("R9 no overrun yet", {15'd0, overrun}, 16'd0);
    push_rx(16'h77EE);
    check("R9 overrun set", {15'd0, overrun}, 16'd1);
    for (int i = 0; i < 8; i++) begin
      bus_read(2'd0, d); check("R9 kept frames", d, 16'h5500 + 16'(i));
    end
    peek(2'd1, d); check("R9 dropped frame absent", d, 16'h0003);
    check("R9 sticky", {15'd0, overrun}, 16'd1);
  endtask

  task automatic measure(input string req, input int div);
    int first = -1;
    int gap = -1;
    for (int c = 0; c < 3 * div + 10 && gap < 0; c++) begin
      @(negedge clk);
      if (sck_en) begin
        if (first < 0) first = c;
        else gap = c - first;
      end
    end
    check(req, 16'(gap), 16'(div));
  endtask

  task automatic t_presc();
    logic [15:0] d;
    int hits;
    bus_write(2'd2, 16'h0007);
    peek(2'd2, d); check("R10 odd forced even", d, 16'h0006);
    measure("R11 period 6", 6);
    bus_write(2'd2, 16'h0002);
    measure("R11 period 2", 2);
    bus_write(2'd2, 16'h00FF);
    peek(2'd2, d); check("R10 max", d, 16'h00FE);
    measure("R11 period 254", 254);
    bus_write(2'd2, 16'h0001);
    peek(2'd2, d); check("R10 one stored as zero", d, 16'h0000);
    hits = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (sck_en) hits++;
    end
    check("R11 zero divisor silent", 16'(hits), 16'd0);
  endtask

  task automatic t_status_wr();
    logic [15:0] d;
    bus_write(2'd2, 16'h0010);
    bus_write(2'd1, 16'hFFFF);
    bus_write(2'd3, 16'hFFFF);
    peek(2'd1, d); check("R12 status unchanged", d, 16'h0003);
    check("R12 no tx push", {15'd0, tx_valid}, 16'd0);
    peek(2'd2, d); check("R12 prescale unchanged", d, 16'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_fill();
    t_mask();
    t_busy();
    t_rx();
    t_overrun();
    t_presc();
    t_status_wr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule